// File: doc/BRIEF.md
# Burst-to-Beat Address Sequencer

This block sits between a master that issues burst commands on a memory-mapped address channel and a slave that only handles single transfers. Each command carries a start address, a burst mode, a beat count minus one (`len`), a transfer size and a transaction id. A valid/ready handshake accepts the command. The block then produces one single-transfer address beat per transfer on a second valid/ready stream, each with its own address.

Three addressing modes are supported. Hold mode repeats the start address on every beat. Step mode adds the transfer size to the address on every beat. Ring mode steps through a window aligned to its own size and wraps back to the window base. The id, mode, len and size fields are copied unchanged onto every beat, and a last flag marks the final beat.

Either side may stall at any time. The block holds one burst at a time. A new command is taken only after the last beat of the current burst has been handed over.

Top module: `burst_beat_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when no burst is in progress. A command offered while a burst is active is ignored and does not change the beats being produced. `in_ready` returns to 1 in the cycle after the handshake of the last beat.
- R3: A command with length field `len` (0 to 255) produces exactly `len`+1 output handshakes. `out_last` is 1 on beat number `len` and 0 on every earlier beat.
- R4: Mode code 0 (hold), and the unused code 3, put the start address on every beat.
- R5: Mode code 1 (step) gives beat i the address start + i·2^size, modulo 2^ADDR_W. Here size is the 3-bit log2 of bytes per beat, so size 2 means 4 bytes.
- R6: Mode code 2 (ring), with len+1 in {2,4,8,16}, uses a window of W = 2^size·(len+1) bytes whose base is the start address rounded down to a multiple of W. Beat i has address base + ((start − base + i·2^size) mod W).
- R7: `out_id`, `out_mode`, `out_len` and `out_size` equal the accepted command's fields on every beat of its burst.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value, and no beat is lost or repeated whatever the `out_ready` pattern.
- R9: The first beat is presented with `out_valid` = 1 in the cycle after the command handshake, and it carries the start address in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command can be accepted |
| in_addr | input | ADDR_W | Start byte address |
| in_mode | input | 2 | Burst mode: 0 hold, 1 step, 2 ring, 3 treated as hold |
| in_len | input | LEN_W | Beats minus one |
| in_size | input | 3 | log2 of bytes per beat |
| in_id | input | ID_W | Transaction id |
| out_valid | output | 1 | Beat presented |
| out_ready | input | 1 | Beat taken by the slave |
| out_addr | output | ADDR_W | Address of this beat |
| out_mode | output | 2 | Copied mode |
| out_len | output | LEN_W | Copied length |
| out_size | output | 3 | Copied size |
| out_id | output | ID_W | Copied id |
| out_last | output | 1 | Final beat of the burst |

## Verification
The assertions check on every cycle:
- the output hold-under-stall rule;
- the mutual exclusion of `in_ready` and an active burst;
- that the first beat appears with the start address;
- that beats keep coming until the last one;
- that hold mode repeats and step mode advances by exactly 2^size per handshake.

Only the bench scenarios can show the whole per-beat address sequence, including:
- the ring wrap back to the aligned base;
- the exact beat count for lengths 0 and 255;
- address rollover at the top of the address space;
- that commands offered during a burst leave it untouched.

These scenarios compare against addresses computed independently from the mode rules.

// File: rtl/bbg_pkg.sv
package bbg_pkg;
  localparam int SIZE_W = 3;
  localparam logic [1:0] MODE_HOLD = 2'd0;
  localparam logic [1:0] MODE_STEP = 2'd1;
  localparam logic [1:0] MODE_RING = 2'd2;

  // Address of beat idx of a burst, computed on a 64-bit scratch width.
  function automatic logic [63:0] beat_address(
    input logic [63:0]       start,
    input logic [1:0]        mode,
    input logic [15:0]       beats_m1,
    input logic [SIZE_W-1:0] size,
    input logic [15:0]       idx
  );
    logic [63:0] step;
    logic [63:0] lin;
    logic [63:0] win_mask;
    step     = {48'b0, idx} << size;
    lin      = start + step;
    win_mask = (({48'b0, beats_m1} + 64'd1) << size) - 64'd1;
    case (mode)
      MODE_STEP: beat_address = lin;
      MODE_RING: beat_address = (start & ~win_mask) | (lin & win_mask);
      default:   beat_address = start;
    endcase
  endfunction
endpackage

// File: rtl/bbg_cmd_hold.sv
module bbg_cmd_hold #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       clear,
  input  logic [ADDR_W-1:0]          d_addr,
  input  logic [1:0]                 d_mode,
  input  logic [LEN_W-1:0]           d_len,
  input  logic [bbg_pkg::SIZE_W-1:0] d_size,
  input  logic [ID_W-1:0]            d_id,
  output logic [ADDR_W-1:0]          q_addr,
  output logic [1:0]                 q_mode,
  output logic [LEN_W-1:0]           q_len,
  output logic [bbg_pkg::SIZE_W-1:0] q_size,
  output logic [ID_W-1:0]            q_id,
  output logic                       busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      q_addr <= '0;
      q_mode <= '0;
      q_len  <= '0;
      q_size <= '0;
      q_id   <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      q_addr <= d_addr;
      q_mode <= d_mode;
      q_len  <= d_len;
      q_size <= d_size;
      q_id   <= d_id;
    end else if (clear) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/bbg_beat_count.sv
module bbg_beat_count #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] idx,
  output logic             at_last
);
  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (restart) idx <= '0;
    else if (advance) idx <= idx + 1'b1;
  end

  assign at_last = (idx == len);
endmodule

// File: rtl/bbg_addr_unit.sv
module bbg_addr_unit #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0]          start,
  input  logic [1:0]                 mode,
  input  logic [LEN_W-1:0]           len,
  input  logic [bbg_pkg::SIZE_W-1:0] size,
  input  logic [LEN_W-1:0]           idx,
  output logic [ADDR_W-1:0]          addr
);
  logic [63:0] full;

  always_comb begin
    full = bbg_pkg::beat_address(64'(start), mode, 16'(len), size, 16'(idx));
    addr = full[ADDR_W-1:0];
  end
endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic [1:0]                 in_mode,
  input  logic [LEN_W-1:0]           in_len,
  input  logic [bbg_pkg::SIZE_W-1:0] in_size,
  input  logic [ID_W-1:0]            in_id,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [ADDR_W-1:0]          out_addr,
  output logic [1:0]                 out_mode,
  output logic [LEN_W-1:0]           out_len,
  output logic [bbg_pkg::SIZE_W-1:0] out_size,
  output logic [ID_W-1:0]            out_id,
  output logic                       out_last
);
  logic             busy;
  logic             cmd_fire;
  logic             beat_fire;
  logic             burst_end;
  logic             at_last;
  logic [LEN_W-1:0] beat_idx;
  logic [ADDR_W-1:0] start_addr;

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign cmd_fire  = in_valid && in_ready;
  assign beat_fire = out_valid && out_ready;
  assign burst_end = beat_fire && at_last;
  assign out_last  = at_last;

  bbg_cmd_hold #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(cmd_fire), .clear(burst_end),
    .d_addr(in_addr), .d_mode(in_mode), .d_len(in_len), .d_size(in_size), .d_id(in_id),
    .q_addr(start_addr), .q_mode(out_mode), .q_len(out_len), .q_size(out_size), .q_id(out_id),
    .busy(busy)
  );

  bbg_beat_count #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(cmd_fire), .advance(beat_fire),
    .len(out_len), .idx(beat_idx), .at_last(at_last)
  );

  bbg_addr_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .start(start_addr), .mode(out_mode), .len(out_len), .size(out_size),
    .idx(beat_idx), .addr(out_addr)
  );
endmodule

// File: rtl/bbg_checker.sv
module bbg_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [ADDR_W-1:0]          in_addr,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [ADDR_W-1:0]          out_addr,
  input logic [1:0]                 out_mode,
  input logic [LEN_W-1:0]           out_len,
  input logic [bbg_pkg::SIZE_W-1:0] out_size,
  input logic [ID_W-1:0]            out_id,
  input logic                       out_last
);
  logic take_mid;
  assign take_mid = out_valid && out_ready && !out_last;

  assert_idle_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_id)
      && $stable(out_last) && $stable(out_len) && $stable(out_size) && $stable(out_mode));

  assert_first_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_addr == $past(in_addr));

  assert_continue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_mid |=> out_valid);

  assert_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

  assert_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_mid |=> $stable(out_id) && $stable(out_len) && $stable(out_size) && $stable(out_mode));

  assert_hold_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_mid && (out_mode == 2'd0 || out_mode == 2'd3) |=> $stable(out_addr));

  assert_step_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_mid && out_mode == 2'd1 |=>
      out_addr == ADDR_W'($past(out_addr) + (ADDR_W'(1) << $past(out_size))));
endmodule

bind burst_beat_gen bbg_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W)) u_bbg_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_mode(out_mode),
  .out_len(out_len), .out_size(out_size), .out_id(out_id), .out_last(out_last)
);

// File: tb/burst_beat_gen_test.sv
module burst_beat_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_mode = '0;
  logic [7:0]  in_len = '0;
  logic [2:0]  in_size = '0;
  logic [7:0]  in_id = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [1:0]  out_mode;
  logic [7:0]  out_len;
  logic [2:0]  out_size;
  logic [7:0]  out_id;
  logic        out_last;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_beat_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mode(in_mode), .in_len(in_len), .in_size(in_size), .in_id(in_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_mode(out_mode),
    .out_len(out_len), .out_size(out_size), .out_id(out_id), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic longint model_addr(longint start, int mode, int len, int size, int i);
    longint bytes, win, base;
    bytes = longint'(1) << size;
    if (mode == 1) return (start + i * bytes) % 64'h1_0000_0000;
    if (mode == 2) begin
      win  = (len + 1) * bytes;
      base = start - (start % win);
      return base + ((start - base + i * bytes) % win);
    end
    return start;
  endfunction

  // Offer one command, collect all its beats with out_ready asserted at ready_pct percent.
  task automatic run_burst(input logic [31:0] a, input int mode, input int len, input int size,
                           input int id, input int ready_pct, input bit junk);
    bit rdy;
    int beat;
    int cyc;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_mode = 2'(mode); in_len = 8'(len);
    in_size = 3'(size); in_id = 8'(id);
    forever begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R9 valid after accept", longint'(out_valid), 1);
    chk(out_addr === a, "R9 first address", longint'(out_addr), longint'(a));
    if (junk) begin
      for (int k = 0; k < 3; k++) begin
        in_valid = 1'b1; in_addr = ~a; in_mode = 2'(mode + 1); in_len = 8'(len + 3);
        in_id = 8'(id + 1); out_ready = 1'b0;
        chk(in_ready === 1'b0, "R2 busy blocks input", longint'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    beat = 0;
    cyc = 0;
    while (beat <= len) begin
      out_ready = (($urandom % 100) < 32'(ready_pct)) || (cyc > 20);
      chk(out_valid === 1'b1, "R3 beat present", longint'(out_valid), 1);
      chk(out_addr === 32'(model_addr(longint'(a), mode, len, size, beat)),
          (mode == 2) ? "R6 ring address" : (mode == 1) ? "R5 step address" : "R4 hold address",
          longint'(out_addr), model_addr(longint'(a), mode, len, size, beat));
      chk(out_last === (beat == len), "R3 last flag", longint'(out_last), longint'(beat == len));
      chk(out_id === 8'(id) && out_len === 8'(len) && out_size === 3'(size) && out_mode === 2'(mode),
          "R7 fields", longint'({out_id, out_len, out_size, out_mode}),
          longint'({8'(id), 8'(len), 3'(size), 2'(mode)}));
      if (!out_ready) cyc++;
      @(posedge clk);
      if (out_ready) begin beat++; cyc = 0; end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R3 no extra beat", longint'(out_valid), 0);
    chk(in_ready === 1'b1, "R2 ready after last", longint'(in_ready), 1);
    repeat ($urandom % 3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 reset in_ready", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset", longint'({out_valid, in_ready}), 1);

    run_burst(32'h0000_0004, 2, 3, 1, 5, 100, 1'b0);   // R6: 4,6,0,2
    run_burst(32'h0000_1038, 2, 15, 2, 6, 60, 1'b0);   // R6 16 beats
    run_burst(32'h1000_0000, 1, 0, 2, 7, 50, 1'b0);    // R3 single beat
    run_burst(32'h0000_0100, 1, 255, 2, 8, 70, 1'b0);  // R3 longest
    run_burst(32'hFFFF_FFF8, 1, 5, 2, 9, 50, 1'b0);    // R5 rollover
    run_burst(32'h0000_2222, 0, 7, 2, 10, 40, 1'b1);   // R4 hold, R2 ignored input
    run_burst(32'h0000_3333, 3, 4, 0, 11, 50, 1'b0);   // R4 unused code 3
    run_burst(32'h0000_4000, 1, 6, 0, 12, 20, 1'b1);   // R8 heavy stall

    for (int n = 0; n < 60; n++) begin
      int md, ln, sz;
      md = int'($urandom % 3);
      sz = int'($urandom % 3);
      if (md == 2) ln = (2 << ($urandom % 4)) - 1;
      else ln = int'($urandom % 24);
      run_burst($urandom, md, ln, sz, int'($urandom % 256), int'($urandom % 91) + 10, 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule